// File: doc/BRIEF.md
# Cascaded Timer Pair with Write Contention

This block chains two 16-bit timers. The lower counter steps up or down on every enabled clock. Each time it wraps, the carry or borrow is the only thing that moves the upper counter, one step in the same direction. A third, auxiliary counter runs beside the pair. Its three registers can act as compare registers, or they can latch the auxiliary count on every upper-counter step. The upper counter's second register can work as a compare register, or it can capture the upper count on an event from the auxiliary register C.

Software reaches every counter and register through one synchronous write port. Written data lands in the target register on the clock edge after the strobe.

The block fixes what happens when software writes the lower counter in the very cycle it would wrap. The write wins, and the carry or borrow for that cycle is dropped. Compare detection and the capture chains keep working in that cycle. Clearing always resets both chained counters on the same edge.

Top module: `casc_timer_pair`

## Requirements
- R1: With `cntEn` high and no write to the lower counter and no clear, the lower counter wrapping raises `carryOut` in that cycle. The wrap is 16'hFFFF to 16'h0000 when `cntDown`=0, and 16'h0000 to 16'hFFFF when `cntDown`=1. On the same edge the upper counter moves one step in the direction set by `cntDown`, and it wraps at its own limits too.
- R2: A write to the lower counter (`wrSel`=0) in the cycle where the lower counter would wrap behaves as follows. The written value is loaded, `carryOut` stays low, and the upper counter keeps its value.
- R3: A write to the lower counter one cycle before or one cycle after its wrap does not block the carry. If the counter still reaches its wrap value, the upper counter steps once.
- R4: The lower counter adds 1 (`cntDown`=0) or subtracts 1 (`cntDown`=1) on each edge while `cntEn` is high. A write takes effect on the edge after the strobe and replaces the step.
- R5: Each match output is a one-cycle pulse, high in the first cycle that a counter equals its compare register. For `hiMatchA` this holds even in a cycle where the upper step was suppressed.
- R6: With `auxCapSel`=1, `auxRegA`, `auxRegB` and `auxRegC` load the auxiliary count on every edge where `carryOut` is high. In this mode `auxMatchA`, `auxMatchB` and `auxMatchC` stay low.
- R7: With `hiBCapSel`=1, `hiRegB` loads the upper count when the auxiliary C event occurs. That event is `carryOut` when `auxCapSel`=1, and the `auxRegC` compare pulse when `auxCapSel`=0. A capture takes precedence over a software write to the same register.
- R8: `clrPair` zeroes the lower and upper counters on the same edge, ahead of writes and counting. The auxiliary counter is left untouched.
- R9: After reset, all three counters read 0 and all compare and capture registers read 16'hFFFF.
- R10: The write select codes are: 0 lower counter, 1 upper counter, 2 auxiliary counter, 3 lower compare, 4 upper register A, 5 upper register B, 6 to 8 auxiliary registers A to C. Other codes write nothing.
- R11: The auxiliary counter counts up by one on each edge with `cntEn` high, whatever the value of `cntDown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 4 | Write target code |
| wrData | input | 16 | Write data |
| cntEn | input | 1 | Count enable for lower and auxiliary counters |
| cntDown | input | 1 | 1 = count down |
| clrPair | input | 1 | Clear lower and upper counters together |
| auxCapSel | input | 1 | Auxiliary registers capture on upper steps |
| hiBCapSel | input | 1 | Upper register B captures on auxiliary C event |
| loCount | output | 16 | Lower counter |
| hiCount | output | 16 | Upper counter |
| auxCount | output | 16 | Auxiliary counter |
| hiRegB | output | 16 | Upper register B |
| auxRegA | output | 16 | Auxiliary register A |
| auxRegB | output | 16 | Auxiliary register B |
| auxRegC | output | 16 | Auxiliary register C |
| carryOut | output | 1 | Step strobe into the upper counter |
| loMatch | output | 1 | Lower compare pulse |
| hiMatchA | output | 1 | Upper register A compare pulse |
| hiMatchB | output | 1 | Upper register B compare pulse (compare mode) |
| auxMatchA | output | 1 | Auxiliary A compare pulse (compare mode) |
| auxMatchB | output | 1 | Auxiliary B compare pulse (compare mode) |
| auxMatchC | output | 1 | Auxiliary C compare pulse (compare mode) |

## Verification
The hardest case to reach is a software write that lands in exactly the cycle where the lower counter sits at its wrap value. The stimulus preloads the lower counter a fixed distance from the wrap in each direction. It then runs a fixed number of counting cycles and places the write on a chosen cycle offset: before, at, or after the wrap. This makes the contention cycle exact.

The capture chains are reached the same way. The auxiliary count and its register C are preset so that the C event falls on a known cycle. The upper count captured at that moment is then checked.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;

  typedef enum logic [3:0] {
    SEL_LO_CNT  = 4'd0,
    SEL_HI_CNT  = 4'd1,
    SEL_AUX_CNT = 4'd2,
    SEL_LO_CMP  = 4'd3,
    SEL_HI_CMPA = 4'd4,
    SEL_HI_REGB = 4'd5,
    SEL_AUX_A   = 4'd6,
    SEL_AUX_B   = 4'd7,
    SEL_AUX_C   = 4'd8
  } regSel_e;

  // strobes from control into datapath
  typedef struct packed {
    logic clrPair;
    logic loLoad;
    logic hiLoad;
    logic auxLoad;
    logic loCmpLoad;
    logic hiCmpLoad;
    logic hiBLoad;
    logic auxALoad;
    logic auxBLoad;
    logic auxCLoad;
    logic loStep;
    logic hiStep;
    logic auxStep;
    logic stepDown;
    logic auxCapture;
    logic hiBCapture;
    logic hiBIsCmp;
    logic auxIsCmp;
  } ctrlStrobe_t;

  // flags from datapath back to control
  typedef struct packed {
    logic loAtMax;
    logic loAtMin;
    logic auxCEdge;
  } dpStatus_t;

endpackage

// File: rtl/casc_timer_ctrl.sv
module casc_timer_ctrl
  import casc_timer_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             cntEn,
  input  logic             cntDown,
  input  logic             clrPair,
  input  logic             auxCapSel,
  input  logic             hiBCapSel,
  input  dpStatus_t        status,
  output ctrlStrobe_t      strobes
);

  logic wrLo, wrHi, wrAux, wrLoCmp, wrHiCmp, wrHiB, wrAuxA, wrAuxB, wrAuxC;
  logic wrapNow, carry, auxCEvent;

  always_comb begin
    wrLo    = wrEn && (wrSel == SEL_LO_CNT);
    wrHi    = wrEn && (wrSel == SEL_HI_CNT);
    wrAux   = wrEn && (wrSel == SEL_AUX_CNT);
    wrLoCmp = wrEn && (wrSel == SEL_LO_CMP);
    wrHiCmp = wrEn && (wrSel == SEL_HI_CMPA);
    wrHiB   = wrEn && (wrSel == SEL_HI_REGB);
    wrAuxA  = wrEn && (wrSel == SEL_AUX_A);
    wrAuxB  = wrEn && (wrSel == SEL_AUX_B);
    wrAuxC  = wrEn && (wrSel == SEL_AUX_C);
  end

  // wrap of the lower counter; a write to it or a clear kills the carry
  assign wrapNow   = cntEn && (cntDown ? status.loAtMin : status.loAtMax);
  assign carry     = wrapNow && !wrLo && !clrPair;
  assign auxCEvent = auxCapSel ? carry : status.auxCEdge;

  always_comb begin
    strobes            = '0;
    strobes.clrPair    = clrPair;
    strobes.loLoad     = wrLo && !clrPair;
    strobes.hiLoad     = wrHi && !clrPair;
    strobes.auxLoad    = wrAux;
    strobes.loCmpLoad  = wrLoCmp;
    strobes.hiCmpLoad  = wrHiCmp;
    strobes.hiBLoad    = wrHiB;
    strobes.auxALoad   = wrAuxA;
    strobes.auxBLoad   = wrAuxB;
    strobes.auxCLoad   = wrAuxC;
    strobes.loStep     = cntEn && !wrLo && !clrPair;
    strobes.hiStep     = carry;
    strobes.auxStep    = cntEn;
    strobes.stepDown   = cntDown;
    strobes.auxCapture = auxCapSel && carry;
    strobes.hiBCapture = hiBCapSel && auxCEvent;
    strobes.hiBIsCmp   = !hiBCapSel;
    strobes.auxIsCmp   = !auxCapSel;
  end

endmodule

// File: rtl/casc_timer_dp.sv
module casc_timer_dp
  import casc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobe_t  strobes,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] loCount,
  output logic [W-1:0] hiCount,
  output logic [W-1:0] auxCount,
  output logic [W-1:0] hiRegB,
  output logic [W-1:0] auxRegA,
  output logic [W-1:0] auxRegB,
  output logic [W-1:0] auxRegC,
  output logic         loMatch,
  output logic         hiMatchA,
  output logic         hiMatchB,
  output logic         auxMatchA,
  output logic         auxMatchB,
  output logic         auxMatchC,
  output dpStatus_t    status
);

  localparam int NCMP = 6;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] RST_REG = '1;

  logic [W-1:0] loCmp, hiCmpA;

  function automatic logic [W-1:0] stepVal(input logic [W-1:0] v, input logic down);
    return down ? (v - ONE) : (v + ONE);
  endfunction

  // chained counters
  always_ff @(posedge clk) begin
    if (!rstN)                loCount <= '0;
    else if (strobes.clrPair) loCount <= '0;
    else if (strobes.loLoad)  loCount <= wrData;
    else if (strobes.loStep)  loCount <= stepVal(loCount, strobes.stepDown);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                hiCount <= '0;
    else if (strobes.clrPair) hiCount <= '0;
    else if (strobes.hiLoad)  hiCount <= wrData;
    else if (strobes.hiStep)  hiCount <= stepVal(hiCount, strobes.stepDown);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                auxCount <= '0;
    else if (strobes.auxLoad) auxCount <= wrData;
    else if (strobes.auxStep) auxCount <= auxCount + ONE;
  end

  // compare-only registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loCmp  <= RST_REG;
      hiCmpA <= RST_REG;
    end else begin
      if (strobes.loCmpLoad) loCmp  <= wrData;
      if (strobes.hiCmpLoad) hiCmpA <= wrData;
    end
  end

  // dual-role registers: capture beats write
  always_ff @(posedge clk) begin
    if (!rstN)                   hiRegB <= RST_REG;
    else if (strobes.hiBCapture) hiRegB <= hiCount;
    else if (strobes.hiBLoad)    hiRegB <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxRegA <= RST_REG;
      auxRegB <= RST_REG;
      auxRegC <= RST_REG;
    end else if (strobes.auxCapture) begin
      auxRegA <= auxCount;
      auxRegB <= auxCount;
      auxRegC <= auxCount;
    end else begin
      if (strobes.auxALoad) auxRegA <= wrData;
      if (strobes.auxBLoad) auxRegB <= wrData;
      if (strobes.auxCLoad) auxRegC <= wrData;
    end
  end

  // compare edge detectors
  logic [W-1:0]    cmpCnt [NCMP];
  logic [W-1:0]    cmpRef [NCMP];
  logic [NCMP-1:0] cmpOn, eqNow, eqPrev, edgeHit;

  assign cmpCnt[0] = loCount;  assign cmpRef[0] = loCmp;   assign cmpOn[0] = 1'b1;
  assign cmpCnt[1] = hiCount;  assign cmpRef[1] = hiCmpA;  assign cmpOn[1] = 1'b1;
  assign cmpCnt[2] = hiCount;  assign cmpRef[2] = hiRegB;  assign cmpOn[2] = strobes.hiBIsCmp;
  assign cmpCnt[3] = auxCount; assign cmpRef[3] = auxRegA; assign cmpOn[3] = strobes.auxIsCmp;
  assign cmpCnt[4] = auxCount; assign cmpRef[4] = auxRegB; assign cmpOn[4] = strobes.auxIsCmp;
  assign cmpCnt[5] = auxCount; assign cmpRef[5] = auxRegC; assign cmpOn[5] = strobes.auxIsCmp;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign eqNow[i]   = (cmpCnt[i] == cmpRef[i]);
    assign edgeHit[i] = eqNow[i] && !eqPrev[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) eqPrev <= '0;
    else       eqPrev <= eqNow;
  end

  assign loMatch   = edgeHit[0] && cmpOn[0];
  assign hiMatchA  = edgeHit[1] && cmpOn[1];
  assign hiMatchB  = edgeHit[2] && cmpOn[2];
  assign auxMatchA = edgeHit[3] && cmpOn[3];
  assign auxMatchB = edgeHit[4] && cmpOn[4];
  assign auxMatchC = edgeHit[5] && cmpOn[5];

  assign status.loAtMax  = &loCount;
  assign status.loAtMin  = ~|loCount;
  assign status.auxCEdge = edgeHit[5];

endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
  import casc_timer_pkg::*;
#(
  parameter int W     = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [W-1:0]     wrData,
  input  logic             cntEn,
  input  logic             cntDown,
  input  logic             clrPair,
  input  logic             auxCapSel,
  input  logic             hiBCapSel,
  output logic [W-1:0]     loCount,
  output logic [W-1:0]     hiCount,
  output logic [W-1:0]     auxCount,
  output logic [W-1:0]     hiRegB,
  output logic [W-1:0]     auxRegA,
  output logic [W-1:0]     auxRegB,
  output logic [W-1:0]     auxRegC,
  output logic             carryOut,
  output logic             loMatch,
  output logic             hiMatchA,
  output logic             hiMatchB,
  output logic             auxMatchA,
  output logic             auxMatchB,
  output logic             auxMatchC
);

  ctrlStrobe_t strobes;
  dpStatus_t   status;

  casc_timer_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel), .cntEn(cntEn), .cntDown(cntDown),
    .clrPair(clrPair), .auxCapSel(auxCapSel), .hiBCapSel(hiBCapSel),
    .status(status), .strobes(strobes)
  );

  casc_timer_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .loCount(loCount), .hiCount(hiCount), .auxCount(auxCount),
    .hiRegB(hiRegB), .auxRegA(auxRegA), .auxRegB(auxRegB), .auxRegC(auxRegC),
    .loMatch(loMatch), .hiMatchA(hiMatchA), .hiMatchB(hiMatchB),
    .auxMatchA(auxMatchA), .auxMatchB(auxMatchB), .auxMatchC(auxMatchC),
    .status(status)
  );

  assign carryOut = strobes.hiStep;

endmodule

// File: rtl/casc_timer_chk.sv
module casc_timer_chk #(
  parameter int W     = 16,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [SEL_W-1:0] wrSel,
  input logic             cntEn,
  input logic             cntDown,
  input logic             clrPair,
  input logic             auxCapSel,
  input logic             hiBCapSel,
  input logic [W-1:0]     loCount,
  input logic [W-1:0]     hiCount,
  input logic [W-1:0]     auxCount,
  input logic [W-1:0]     hiRegB,
  input logic [W-1:0]     auxRegA,
  input logic             carryOut,
  input logic             loMatch,
  input logic             hiMatchA,
  input logic             auxMatchC
);

  a_r2_write_blocks_carry: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_W'(0)) |-> !carryOut);

  a_r1_up_carry: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !cntDown && loCount == '1 && !wrEn && !clrPair) |=>
      hiCount == W'($past(hiCount) + W'(1)));

  a_r1_down_carry: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && cntDown && loCount == '0 && !wrEn && !clrPair) |=>
      hiCount == W'($past(hiCount) - W'(1)));

  a_r8_pair_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrPair |=> (loCount == '0 && hiCount == '0));

  a_r5_hi_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    hiMatchA |=> !hiMatchA);

  a_r5_lo_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    loMatch |=> !loMatch);

  a_r6_aux_capture: assert property (@(posedge clk) disable iff (!rstN)
    (auxCapSel && carryOut) |=> auxRegA == $past(auxCount));

  a_r6_no_aux_match: assert property (@(posedge clk) disable iff (!rstN)
    auxCapSel |-> !auxMatchC);

  a_r7_hib_capture: assert property (@(posedge clk) disable iff (!rstN)
    (hiBCapSel && auxCapSel && carryOut) |=> hiRegB == $past(hiCount));

endmodule

bind casc_timer_pair casc_timer_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .cntEn(cntEn),
  .cntDown(cntDown), .clrPair(clrPair), .auxCapSel(auxCapSel),
  .hiBCapSel(hiBCapSel), .loCount(loCount), .hiCount(hiCount),
  .auxCount(auxCount), .hiRegB(hiRegB), .auxRegA(auxRegA),
  .carryOut(carryOut), .loMatch(loMatch), .hiMatchA(hiMatchA),
  .auxMatchC(auxMatchC)
);

// File: tb/casc_timer_pair_tb.sv
module casc_timer_pair_tb;

  localparam int W = 16;
  localparam int NVEC = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrSel = '0;
  logic [W-1:0] wrData = '0;
  logic cntEn = 1'b0, cntDown = 1'b0, clrPair = 1'b0;
  logic auxCapSel = 1'b0, hiBCapSel = 1'b0;
  logic [W-1:0] loCount, hiCount, auxCount, hiRegB, auxRegA, auxRegB, auxRegC;
  logic carryOut, loMatch, hiMatchA, hiMatchB, auxMatchA, auxMatchB, auxMatchC;

  int checks = 0;
  int errors = 0;

  casc_timer_pair u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cntEn(cntEn), .cntDown(cntDown), .clrPair(clrPair),
    .auxCapSel(auxCapSel), .hiBCapSel(hiBCapSel),
    .loCount(loCount), .hiCount(hiCount), .auxCount(auxCount),
    .hiRegB(hiRegB), .auxRegA(auxRegA), .auxRegB(auxRegB), .auxRegC(auxRegC),
    .carryOut(carryOut), .loMatch(loMatch), .hiMatchA(hiMatchA),
    .hiMatchB(hiMatchB), .auxMatchA(auxMatchA), .auxMatchB(auxMatchB),
    .auxMatchC(auxMatchC)
  );

  always #10 clk = ~clk;

  // {down, write cycle (0 = none), write value, upper start, lower expected, upper expected}
  // lower counter is preset to FFFD (up) or 0002 (down); wrap happens in cycle 2 of 5
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 16'h0000, 16'h0010, 16'h0002, 16'h0011},
    {1'b0, 2'd1, 16'hFFFF, 16'h0010, 16'h0002, 16'h0011},
    {1'b0, 2'd2, 16'h1234, 16'h0010, 16'h1236, 16'h0010},
    {1'b0, 2'd3, 16'h1234, 16'h0010, 16'h1235, 16'h0011},
    {1'b1, 2'd0, 16'h0000, 16'h0010, 16'hFFFD, 16'h000F},
    {1'b1, 2'd1, 16'h0000, 16'h0010, 16'hFFFD, 16'h000F},
    {1'b1, 2'd2, 16'h1234, 16'h0010, 16'h1232, 16'h0010},
    {1'b1, 2'd3, 16'h1234, 16'h0010, 16'h1233, 16'h000F},
    {1'b0, 2'd0, 16'h0000, 16'hFFFF, 16'h0002, 16'h0000},
    {1'b1, 2'd0, 16'h0000, 16'h0000, 16'hFFFD, 16'hFFFF},
    {1'b0, 2'd2, 16'hFFFE, 16'h0005, 16'h0000, 16'h0006}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] sel, input logic [W-1:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick();
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic eDown;
    logic [1:0] eK;
    logic [W-1:0] eWv, eHi, eLo, eHiExp;
    string tag;

    repeat (3) tick();
    rstN = 1'b1;

    // R9 reset values
    check("R9", "loCount", loCount, 16'h0000);
    check("R9", "hiCount", hiCount, 16'h0000);
    check("R9", "auxCount", auxCount, 16'h0000);
    check("R9", "hiRegB", hiRegB, 16'hFFFF);
    check("R9", "auxRegC", auxRegC, 16'hFFFF);
    check("R9", "hiMatchA", {15'd0, hiMatchA}, 16'h0000);

    // write-versus-wrap table: R1 (no write), R2 (write at wrap), R3 (before/after)
    for (int i = 0; i < NVEC; i++) begin
      {eDown, eK, eWv, eHi, eLo, eHiExp} = VEC[i];
      tag = (eK == 2'd0) ? "R1" : (eK == 2'd2) ? "R2" : "R3";
      cntDown = eDown;
      regWrite(4'd1, eHi);
      regWrite(4'd0, eDown ? 16'h0002 : 16'hFFFD);
      for (int c = 0; c < 5; c++) begin
        cntEn = 1'b1;
        if (c == int'(eK) && eK != 2'd0) begin
          wrEn = 1'b1; wrSel = 4'd0; wrData = eWv;
        end else begin
          wrEn = 1'b0;
        end
        tick();
      end
      cntEn = 1'b0; wrEn = 1'b0;
      check(tag, "hiCount", hiCount, eHiExp);
      check("R4", "loCount", loCount, eLo);
    end

    // R5: upper compare pulse in the cycle its step is suppressed
    cntDown = 1'b0;
    regWrite(4'd4, 16'h0050);
    regWrite(4'd0, 16'hFFFF);
    wrEn = 1'b1; wrSel = 4'd1; wrData = 16'h0050;
    tick();
    wrSel = 4'd0; wrData = 16'h0100; cntEn = 1'b1;
    #1;
    check("R5", "hiMatchA first equal", {15'd0, hiMatchA}, 16'h0001);
    check("R2", "carryOut at contention", {15'd0, carryOut}, 16'h0000);
    tick();
    cntEn = 1'b0; wrEn = 1'b0;
    check("R2", "hiCount held", hiCount, 16'h0050);
    check("R5", "hiMatchA one cycle", {15'd0, hiMatchA}, 16'h0000);

    // R5: lower compare pulse
    regWrite(4'd3, 16'h0005);
    regWrite(4'd0, 16'h0003);
    cntEn = 1'b1;
    tick();
    check("R5", "loMatch at 4", {15'd0, loMatch}, 16'h0000);
    tick();
    check("R5", "loMatch at 5", {15'd0, loMatch}, 16'h0001);
    tick();
    cntEn = 1'b0;
    check("R5", "loMatch at 6", {15'd0, loMatch}, 16'h0000);

    // R6/R7: capture on upper step
    auxCapSel = 1'b1; hiBCapSel = 1'b1;
    regWrite(4'd2, 16'h0100);
    regWrite(4'd1, 16'h0077);
    regWrite(4'd0, 16'hFFFE);
    cntEn = 1'b1;
    tick();
    check("R1", "carryOut at FFFF", {15'd0, carryOut}, 16'h0001);
    tick();
    cntEn = 1'b0;
    check("R6", "auxRegA", auxRegA, 16'h0101);
    check("R6", "auxRegB", auxRegB, 16'h0101);
    check("R6", "auxRegC", auxRegC, 16'h0101);
    check("R6", "auxMatchC gated", {15'd0, auxMatchC}, 16'h0000);
    check("R7", "hiRegB from carry", hiRegB, 16'h0077);
    check("R1", "hiCount stepped", hiCount, 16'h0078);
    check("R11", "auxCount", auxCount, 16'h0102);

    // R7: capture on auxiliary C compare
    auxCapSel = 1'b0;
    regWrite(4'd8, 16'h0203);
    regWrite(4'd2, 16'h0200);
    regWrite(4'd1, 16'h0033);
    regWrite(4'd0, 16'h0000);
    cntEn = 1'b1;
    repeat (3) tick();
    check("R7", "auxMatchC", {15'd0, auxMatchC}, 16'h0001);
    tick();
    cntEn = 1'b0;
    check("R7", "hiRegB from C match", hiRegB, 16'h0033);
    hiBCapSel = 1'b0;

    // R8: clear beats a lower write; auxiliary keeps counting
    clrPair = 1'b1; cntEn = 1'b1;
    wrEn = 1'b1; wrSel = 4'd0; wrData = 16'h0999;
    tick();
    clrPair = 1'b0; cntEn = 1'b0; wrEn = 1'b0;
    check("R8", "loCount", loCount, 16'h0000);
    check("R8", "hiCount", hiCount, 16'h0000);
    check("R8", "auxCount", auxCount, 16'h0205);

    // R10: unused select code writes nothing
    regWrite(4'hF, 16'h4444);
    check("R10", "loCount", loCount, 16'h0000);
    check("R10", "hiCount", hiCount, 16'h0000);
    check("R10", "auxCount", auxCount, 16'h0205);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule